// File: doc/BRIEF.md
# Exception Arbiter and Restart Sequencer

This block sits next to the completion stage of a simple in-order core and decides when an exception is taken and which one it is. Requests come from two places. The pipeline reports an instruction that faulted at completion. Event lines carry the external interrupt, the system-management interrupt, the decrementer, machine check and system reset. Maskable events are honoured only while the interrupt-enable bit of the live status word is set. They wait for an instruction boundary: they are taken either on the cycle an instruction completes or at once when nothing is in flight. Nonmaskable events are taken on the cycle they arrive.

When an exception is taken, the block writes a restart address into the first save register and a copy of the live status word into the second. It then clears the enable and recoverable bits of the live status and, on the next cycle, issues a one-cycle fetch redirect to a vector derived from the exception code. A return-from-exception strobe reverses this. It reloads the status from the second save register and redirects fetch to the address held in the first. A status-write strobe lets the handler set the enable and recoverable bits.

Top module: `exc_sequencer`

## Requirements
- R1: After reset the live status equals the reset parameter (default 0), both save registers read 0, and no redirect is issued.
- R2: When several requests are present in the same cycle, they are taken in this order: system reset, machine check, instruction fault, system-management interrupt, external interrupt, decrementer. A request that loses stays pending and is taken later.
- R3: A maskable request (system-management, external, decrementer) has no effect while status bit 15 (enable) is 0. The enable value used is the one held before any status write in the same cycle.
- R4: While `busy` is high and no instruction completes, a maskable request is deferred. On the cycle `cmp_valid` is high it is taken, and the saved restart address is `cmp_pc` + 4.
- R5: With `busy` low, an enabled maskable request is taken at once, and the saved restart address is `nxt_pc`.
- R6: System reset and machine check act on a rising edge of their line, whatever the enable bit. A held line does not retrigger. If one is taken while `busy` is high and nothing completes, bit 1 (recoverable) of the saved status is cleared.
- R7: A fault of kind 0 (program) saves `flt_pc` as the restart address, and the faulting instruction is not treated as complete.
- R8: A fault of kind 2 (trap) or kind 3 (system call) saves `flt_pc` + 4, so that execution resumes past the instruction.
- R9: The floating-point mode field, status bits 11:10, has no effect. A fault of kind 1 (floating-point enabled) always saves `flt_pc`, exactly as a precise fault does.
- R10: On taking an exception, the second save register receives the prior status and the live enable and recoverable bits are cleared. On the next cycle `redir_valid` pulses for one cycle with `redir_pc` = VEC_BASE + code·256 and `exc_code` = code. The codes are 1 reset, 2 machine check, 3 program, 4 floating-point, 5 trap, 6 system call, 7 system-management, 8 external, 9 decrementer.
- R11: `rfi` reloads the live status from the second save register and pulses a redirect with `redir_pc` equal to the first save register and `exc_code` 0.
- R12: `stat_we` loads `stat_wdata` into the live status on the next edge when no exception or return is taken in that cycle.
- R13: When reset and machine check rise together, reset is taken first and machine check on the following cycle. The second save register then holds the status as reset left it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busy | input | 1 | An instruction is in the execution units |
| nxt_pc | input | AW | Address of the oldest instruction not yet completed |
| cmp_valid | input | 1 | An instruction completes this cycle |
| cmp_pc | input | AW | Address of the completing instruction |
| flt_valid | input | 1 | The instruction at completion faulted |
| flt_kind | input | 2 | Fault kind: 0 program, 1 floating-point, 2 trap, 3 system call |
| flt_pc | input | AW | Address of the faulting instruction |
| irq_ext | input | 1 | External interrupt request (level) |
| irq_smi | input | 1 | System-management interrupt request (level) |
| irq_dec | input | 1 | Decrementer request (level) |
| mchk | input | 1 | Machine check line (edge) |
| sreset | input | 1 | System reset line (edge) |
| rfi | input | 1 | Return-from-exception strobe |
| stat_we | input | 1 | Status write strobe |
| stat_wdata | input | SW | Status write data |
| redir_valid | output | 1 | One-cycle fetch redirect |
| redir_pc | output | AW | Redirect target |
| exc_code | output | 4 | Code of the exception taken, 0 for a return |
| status | output | SW | Live status word |
| save0 | output | AW | Saved restart address |
| save1 | output | SW | Saved status word |

## Verification
The bench keeps the default address width, status width and bit positions, but sets the vector base to 0xFFF00000. That way every redirect target checks the base addition and the code-to-offset shift together, not just the offset. The 4-byte instruction step is kept, so the completed-instruction and trap/system-call restart addresses can be checked against known values. With 16-bit status, the floating-point mode field and the enable and recoverable bits can each be written and observed through the save register.

// File: rtl/exc_pkg.sv
package exc_pkg;

  typedef enum logic [3:0] {
    EXC_NONE = 4'd0,
    EXC_SRST = 4'd1,
    EXC_MCHK = 4'd2,
    EXC_PROG = 4'd3,
    EXC_FPEN = 4'd4,
    EXC_TRAP = 4'd5,
    EXC_SYSC = 4'd6,
    EXC_SMI  = 4'd7,
    EXC_EXT  = 4'd8,
    EXC_DEC  = 4'd9
  } exc_code_t;

  typedef enum logic [1:0] {
    FK_PROG = 2'd0,
    FK_FPEN = 2'd1,
    FK_TRAP = 2'd2,
    FK_SYSC = 2'd3
  } flt_kind_t;

endpackage

// File: rtl/nmi_capture.sv
module nmi_capture #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] line,
  input  logic [N-1:0] clr,
  output logic [N-1:0] req
);

  for (genvar i = 0; i < N; i++) begin : g_line
    logic prev_q, pend_q, pend_d, rise;

    always_comb begin
      rise   = line[i] & ~prev_q;
      req[i] = pend_q | rise;
      pend_d = (pend_q | rise) & ~clr[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev_q <= 1'b0;
        pend_q <= 1'b0;
      end else begin
        prev_q <= line[i];
        pend_q <= pend_d;
      end
    end
  end

endmodule

// File: rtl/exc_pick.sv
module exc_pick
  import exc_pkg::*;
#(
  parameter int AW         = 32,
  parameter int INSN_BYTES = 4
) (
  input  logic [1:0]    nmi_req,   // [0] system reset, [1] machine check
  input  logic          ee,
  input  logic          busy,
  input  logic [AW-1:0] nxt_pc,
  input  logic          cmp_valid,
  input  logic [AW-1:0] cmp_pc,
  input  logic          flt_valid,
  input  logic [1:0]    flt_kind,
  input  logic [AW-1:0] flt_pc,
  input  logic          irq_smi,
  input  logic          irq_ext,
  input  logic          irq_dec,
  output logic          take,
  output logic [3:0]    code,
  output logic [AW-1:0] restart,
  output logic          lose_ri,
  output logic [1:0]    nmi_clr
);

  localparam logic [AW-1:0] STEP = AW'(INSN_BYTES);

  logic          slot_ok;
  logic          mid_flight;
  logic [AW-1:0] base_pc;

  always_comb begin
    slot_ok    = cmp_valid | ~busy;
    mid_flight = busy & ~cmp_valid & ~flt_valid;
    base_pc    = flt_valid ? flt_pc : (cmp_valid ? cmp_pc + STEP : nxt_pc);

    take    = 1'b1;
    code    = EXC_NONE;
    restart = base_pc;
    lose_ri = 1'b0;
    nmi_clr = 2'b00;

    if (nmi_req[0]) begin
      code       = EXC_SRST;
      nmi_clr[0] = 1'b1;
      lose_ri    = mid_flight;
    end else if (nmi_req[1]) begin
      code       = EXC_MCHK;
      nmi_clr[1] = 1'b1;
      lose_ri    = mid_flight;
    end else if (flt_valid) begin
      case (flt_kind)
        FK_PROG: code = EXC_PROG;
        FK_FPEN: code = EXC_FPEN;
        FK_TRAP: begin code = EXC_TRAP; restart = flt_pc + STEP; end
        default: begin code = EXC_SYSC; restart = flt_pc + STEP; end
      endcase
    end else if (ee & slot_ok & irq_smi) begin
      code = EXC_SMI;
    end else if (ee & slot_ok & irq_ext) begin
      code = EXC_EXT;
    end else if (ee & slot_ok & irq_dec) begin
      code = EXC_DEC;
    end else begin
      take = 1'b0;
    end
  end

endmodule

// File: rtl/exc_state.sv
module exc_state
  import exc_pkg::*;
#(
  parameter int          AW        = 32,
  parameter int          SW        = 16,
  parameter int          EE_BIT    = 15,
  parameter int          RI_BIT    = 1,
  parameter int          VEC_SHIFT = 8,
  parameter logic [63:0] VEC_BASE  = 64'h0,
  parameter logic [63:0] STAT_RST  = 64'h0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic [3:0]    code,
  input  logic [AW-1:0] restart,
  input  logic          lose_ri,
  input  logic          rfi,
  input  logic          stat_we,
  input  logic [SW-1:0] stat_wdata,
  output logic          redir_valid,
  output logic [AW-1:0] redir_pc,
  output logic [3:0]    exc_code,
  output logic [SW-1:0] status,
  output logic [AW-1:0] save0,
  output logic [SW-1:0] save1
);

  localparam logic [AW-1:0] VBASE = AW'(VEC_BASE);
  localparam logic [SW-1:0] SRST  = SW'(STAT_RST);

  logic [SW-1:0] stat_d, sv1_d;
  logic          stat_en;
  logic          rdv_d;
  logic [AW-1:0] rdpc_d;
  logic [3:0]    code_d;

  always_comb begin
    stat_d  = status;
    stat_en = 1'b0;
    sv1_d   = status;
    rdv_d   = 1'b0;
    rdpc_d  = redir_pc;
    code_d  = EXC_NONE;
    if (take) begin
      if (lose_ri) sv1_d[RI_BIT] = 1'b0;
      stat_d[EE_BIT] = 1'b0;
      stat_d[RI_BIT] = 1'b0;
      stat_en = 1'b1;
      rdv_d   = 1'b1;
      rdpc_d  = VBASE + (AW'(code) << VEC_SHIFT);
      code_d  = code;
    end else if (rfi) begin
      stat_d  = save1;
      stat_en = 1'b1;
      rdv_d   = 1'b1;
      rdpc_d  = save0;
    end else if (stat_we) begin
      stat_d  = stat_wdata;
      stat_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status      <= SRST;
      save0       <= '0;
      save1       <= '0;
      redir_valid <= 1'b0;
      redir_pc    <= '0;
      exc_code    <= EXC_NONE;
    end else begin
      if (stat_en) status <= stat_d;
      if (take) begin
        save0 <= restart;
        save1 <= sv1_d;
      end
      redir_valid <= rdv_d;
      if (rdv_d) redir_pc <= rdpc_d;
      exc_code    <= code_d;
    end
  end

endmodule

// File: rtl/exc_sequencer.sv
module exc_sequencer #(
  parameter int          AW         = 32,
  parameter int          SW         = 16,
  parameter int          EE_BIT     = 15,
  parameter int          RI_BIT     = 1,
  parameter int          INSN_BYTES = 4,
  parameter int          VEC_SHIFT  = 8,
  parameter logic [63:0] VEC_BASE   = 64'h0,
  parameter logic [63:0] STAT_RST   = 64'h0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          busy,
  input  logic [AW-1:0] nxt_pc,
  input  logic          cmp_valid,
  input  logic [AW-1:0] cmp_pc,
  input  logic          flt_valid,
  input  logic [1:0]    flt_kind,
  input  logic [AW-1:0] flt_pc,
  input  logic          irq_ext,
  input  logic          irq_smi,
  input  logic          irq_dec,
  input  logic          mchk,
  input  logic          sreset,
  input  logic          rfi,
  input  logic          stat_we,
  input  logic [SW-1:0] stat_wdata,
  output logic          redir_valid,
  output logic [AW-1:0] redir_pc,
  output logic [3:0]    exc_code,
  output logic [SW-1:0] status,
  output logic [AW-1:0] save0,
  output logic [SW-1:0] save1
);

  localparam int NMI_N = 2;

  logic [NMI_N-1:0] nmi_req, nmi_clr;
  logic             take, lose_ri;
  logic [3:0]       code;
  logic [AW-1:0]    restart;

  nmi_capture #(.N(NMI_N)) u_nmi (
    .clk   (clk),
    .rst_n (rst_n),
    .line  ({mchk, sreset}),
    .clr   (nmi_clr),
    .req   (nmi_req)
  );

  exc_pick #(.AW(AW), .INSN_BYTES(INSN_BYTES)) u_pick (
    .nmi_req   (nmi_req),
    .ee        (status[EE_BIT]),
    .busy      (busy),
    .nxt_pc    (nxt_pc),
    .cmp_valid (cmp_valid),
    .cmp_pc    (cmp_pc),
    .flt_valid (flt_valid),
    .flt_kind  (flt_kind),
    .flt_pc    (flt_pc),
    .irq_smi   (irq_smi),
    .irq_ext   (irq_ext),
    .irq_dec   (irq_dec),
    .take      (take),
    .code      (code),
    .restart   (restart),
    .lose_ri   (lose_ri),
    .nmi_clr   (nmi_clr)
  );

  exc_state #(
    .AW(AW), .SW(SW), .EE_BIT(EE_BIT), .RI_BIT(RI_BIT),
    .VEC_SHIFT(VEC_SHIFT), .VEC_BASE(VEC_BASE), .STAT_RST(STAT_RST)
  ) u_state (
    .clk         (clk),
    .rst_n       (rst_n),
    .take        (take),
    .code        (code),
    .restart     (restart),
    .lose_ri     (lose_ri),
    .rfi         (rfi),
    .stat_we     (stat_we),
    .stat_wdata  (stat_wdata),
    .redir_valid (redir_valid),
    .redir_pc    (redir_pc),
    .exc_code    (exc_code),
    .status      (status),
    .save0       (save0),
    .save1       (save1)
  );

endmodule

// File: rtl/exc_sequencer_chk.sv
module exc_sequencer_chk #(
  parameter int AW         = 32,
  parameter int SW         = 16,
  parameter int EE_BIT     = 15,
  parameter int RI_BIT     = 1,
  parameter int INSN_BYTES = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          cmp_valid,
  input logic          flt_valid,
  input logic [AW-1:0] flt_pc,
  input logic          redir_valid,
  input logic [AW-1:0] redir_pc,
  input logic [3:0]    exc_code,
  input logic [SW-1:0] status,
  input logic [AW-1:0] save0,
  input logic [SW-1:0] save1
);

  logic taken, masked_kind, precise_kind, step_kind;
  assign taken        = redir_valid && (exc_code != 4'd0);
  assign masked_kind  = (exc_code == 4'd7) || (exc_code == 4'd8) || (exc_code == 4'd9);
  assign precise_kind = (exc_code == 4'd3) || (exc_code == 4'd4);
  assign step_kind    = (exc_code == 4'd5) || (exc_code == 4'd6);

  // R10
  take_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    taken |-> (!status[EE_BIT] && !status[RI_BIT]));

  // R10
  save_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    taken |-> (save1[EE_BIT] == $past(status[EE_BIT])));

  // R11
  rfi_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (redir_valid && exc_code == 4'd0) |-> (redir_pc == $past(save0) && status == $past(save1)));

  // R3
  mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (redir_valid && masked_kind) |-> $past(status[EE_BIT]));

  // R4
  mask_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (redir_valid && masked_kind) |-> $past(cmp_valid || !busy));

  // R7
  precise_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (redir_valid && precise_kind) |-> (save0 == $past(flt_pc) && $past(flt_valid)));

  // R8
  step_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (redir_valid && step_kind) |-> (save0 == $past(flt_pc) + AW'(INSN_BYTES)));

endmodule

bind exc_sequencer exc_sequencer_chk #(
  .AW(AW), .SW(SW), .EE_BIT(EE_BIT), .RI_BIT(RI_BIT), .INSN_BYTES(INSN_BYTES)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy        (busy),
  .cmp_valid   (cmp_valid),
  .flt_valid   (flt_valid),
  .flt_pc      (flt_pc),
  .redir_valid (redir_valid),
  .redir_pc    (redir_pc),
  .exc_code    (exc_code),
  .status      (status),
  .save0       (save0),
  .save1       (save1)
);

// File: tb/test_exc_sequencer.sv
`timescale 1ns/1ps
module test_exc_sequencer;

  localparam int          AW   = 32;
  localparam int          SW   = 16;
  localparam logic [63:0] VB   = 64'hFFF0_0000;
  localparam logic [31:0] VB32 = 32'hFFF0_0000;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          busy, cmp_valid, flt_valid;
  logic [AW-1:0] nxt_pc, cmp_pc, flt_pc;
  logic [1:0]    flt_kind;
  logic          irq_ext, irq_smi, irq_dec, mchk, sreset, rfi, stat_we;
  logic [SW-1:0] stat_wdata;
  logic          redir_valid;
  logic [AW-1:0] redir_pc, save0;
  logic [3:0]    exc_code;
  logic [SW-1:0] status, save1;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  exc_sequencer #(.AW(AW), .SW(SW), .VEC_BASE(VB)) i_exc_sequencer (
    .clk(clk), .rst_n(rst_n), .busy(busy), .nxt_pc(nxt_pc),
    .cmp_valid(cmp_valid), .cmp_pc(cmp_pc), .flt_valid(flt_valid),
    .flt_kind(flt_kind), .flt_pc(flt_pc), .irq_ext(irq_ext),
    .irq_smi(irq_smi), .irq_dec(irq_dec), .mchk(mchk), .sreset(sreset),
    .rfi(rfi), .stat_we(stat_we), .stat_wdata(stat_wdata),
    .redir_valid(redir_valid), .redir_pc(redir_pc), .exc_code(exc_code),
    .status(status), .save0(save0), .save1(save1)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    busy = 0; cmp_valid = 0; flt_valid = 0; nxt_pc = '0; cmp_pc = '0;
    flt_pc = '0; flt_kind = 2'd0; irq_ext = 0; irq_smi = 0; irq_dec = 0;
    mchk = 0; sreset = 0; rfi = 0; stat_we = 0; stat_wdata = '0;
  endtask

  task automatic wr_stat(input logic [SW-1:0] v);
    @(negedge clk); stat_we = 1; stat_wdata = v;
    @(negedge clk); stat_we = 0;
  endtask

  task automatic t_reset();
    check("R1", "status", 32'(status), 32'h0);
    check("R1", "save0", save0, 32'h0);
    check("R1", "save1", 32'(save1), 32'h0);
    check("R1", "redir_valid", 32'(redir_valid), 32'h0);
  endtask

  task automatic t_ext_idle();
    wr_stat(16'h8002);
    check("R12", "status after write", 32'(status), 32'h8002);
    busy = 0; nxt_pc = 32'h1000; irq_ext = 1;
    @(negedge clk); irq_ext = 0;
    check("R5", "redir_valid", 32'(redir_valid), 32'h1);
    check("R10", "exc_code ext", 32'(exc_code), 32'd8);
    check("R10", "vector ext", redir_pc, VB32 + 32'h800);
    check("R5", "save0 idle", save0, 32'h1000);
    check("R10", "save1", 32'(save1), 32'h8002);
    check("R10", "status cleared", 32'(status), 32'h0);
    @(negedge clk);
    check("R10", "one-cycle pulse", 32'(redir_valid), 32'h0);
    rfi = 1;
    @(negedge clk); rfi = 0;
    check("R11", "rfi redirect", 32'(redir_valid), 32'h1);
    check("R11", "rfi target", redir_pc, 32'h1000);
    check("R11", "rfi code", 32'(exc_code), 32'h0);
    check("R11", "rfi status", 32'(status), 32'h8002);
  endtask

  task automatic t_ee_gate();
    wr_stat(16'h0002);
    busy = 0; nxt_pc = 32'h1100; irq_dec = 1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R3", "no take with enable clear", 32'(redir_valid), 32'h0);
    end
    check("R3", "status untouched", 32'(status), 32'h0002);
    stat_we = 1; stat_wdata = 16'h8002;
    @(negedge clk); stat_we = 0;
    check("R3", "old enable used in write cycle", 32'(redir_valid), 32'h0);
    @(negedge clk); irq_dec = 0;
    check("R3", "taken after enable", 32'(redir_valid), 32'h1);
    check("R3", "code dec", 32'(exc_code), 32'd9);
    check("R5", "save0 dec", save0, 32'h1100);
  endtask

  task automatic t_busy_defer();
    wr_stat(16'h8002);
    busy = 1; nxt_pc = 32'h2000; irq_smi = 1; irq_ext = 1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R4", "deferred while busy", 32'(redir_valid), 32'h0);
    end
    cmp_valid = 1; cmp_pc = 32'h2000;
    @(negedge clk); cmp_valid = 0; irq_smi = 0; irq_ext = 0; busy = 0;
    check("R4", "taken at completion", 32'(redir_valid), 32'h1);
    check("R2", "smi over ext", 32'(exc_code), 32'd7);
    check("R4", "save0 next insn", save0, 32'h2004);
  endtask

  task automatic t_fault();
    wr_stat(16'h8002);
    busy = 1; irq_smi = 1; flt_valid = 1; flt_kind = 2'd0; flt_pc = 32'h3000;
    @(negedge clk); flt_valid = 0; irq_smi = 0; busy = 0;
    check("R2", "fault over smi", 32'(exc_code), 32'd3);
    check("R7", "save0 faulting", save0, 32'h3000);
    check("R7", "vector program", redir_pc, VB32 + 32'h300);
  endtask

  task automatic t_trap_sc();
    flt_valid = 1; flt_kind = 2'd2; flt_pc = 32'h4000;
    @(negedge clk); flt_valid = 0;
    check("R8", "trap code", 32'(exc_code), 32'd5);
    check("R8", "trap save0", save0, 32'h4004);
    flt_valid = 1; flt_kind = 2'd3; flt_pc = 32'h5000;
    @(negedge clk); flt_valid = 0;
    check("R8", "syscall code", 32'(exc_code), 32'd6);
    check("R8", "syscall save0", save0, 32'h5004);
    check("R8", "syscall vector", redir_pc, VB32 + 32'h600);
  endtask

  task automatic t_fpmode();
    wr_stat(16'h8C02);
    flt_valid = 1; flt_kind = 2'd1; flt_pc = 32'h6000;
    @(negedge clk); flt_valid = 0;
    check("R9", "fp code", 32'(exc_code), 32'd4);
    check("R9", "fp save0 precise", save0, 32'h6000);
    check("R9", "fp save1", 32'(save1), 32'h8C02);
  endtask

  task automatic t_nmi_mid();
    wr_stat(16'h0002);
    busy = 1; nxt_pc = 32'h7100; mchk = 1;
    @(negedge clk);
    check("R6", "mchk with enable clear", 32'(exc_code), 32'd2);
    check("R6", "mchk save0", save0, 32'h7100);
    check("R6", "recoverable cleared mid-flight", 32'(save1), 32'h0000);
    @(negedge clk);
    check("R6", "held line no retrigger", 32'(redir_valid), 32'h0);
    mchk = 0; busy = 0;
    @(negedge clk);
  endtask

  task automatic t_nmi_both();
    wr_stat(16'h0002);
    busy = 0; nxt_pc = 32'h7000; sreset = 1; mchk = 1;
    @(negedge clk);
    check("R13", "reset first", 32'(exc_code), 32'd1);
    check("R13", "reset vector", redir_pc, VB32 + 32'h100);
    check("R13", "reset save1", 32'(save1), 32'h0002);
    check("R13", "reset save0", save0, 32'h7000);
    @(negedge clk); sreset = 0; mchk = 0;
    check("R13", "mchk second", 32'(exc_code), 32'd2);
    check("R13", "mchk save1 after reset", 32'(save1), 32'h0000);
    check("R2", "mchk save0", save0, 32'h7000);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_ext_idle();
    t_ee_gate();
    t_busy_defer();
    t_fault();
    t_trap_sc();
    t_fpmode();
    t_nmi_mid();
    t_nmi_both();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule